// File: doc/BRIEF.md
# Bus Cycle Issue Gating Controller

This block decides, clock by clock, whether the processor bus interface may launch the cycle at the head of its internal request queue. Each request is a read or a write. Writes also carry the cache state of the target line. The block emits a single-clock start strobe, and the queue pops its head on that strobe. After the strobe, the block treats the bus as busy until the bus sequencer reports that the cycle is done.

There are two external gates on issue.

- **Write-buffer-empty input (active low).** If a write leaves while this input says the outside world still holds a write, later writes aimed at exclusive or modified lines wait. They are released once the input is seen active.
- **Hold request.** Another master can request the bus. The block grants it at the next cycle boundary, floats its drivers and raises the acknowledge. When the request goes away, the block drops the acknowledge and drives the bus again. Any queued cycle then leaves exactly one clock later.

Top module: `bcg_issue_gate`

## Requirements
- R1: After a synchronous reset, `cyc_start` is 0, `hlda` is 0, `bus_oe` is 1 and the write fence is clear.
- R2: With the bus idle, no hold pending, no hold acknowledge and no fence block, a valid request raises `cyc_start` in the same clock. Once a cycle has started, no further start occurs until the clock after the one in which `cyc_done` is high.
- R3: A write that starts while `wbe_n` is 1 arms a fence. While the fence is armed, a write whose `req_state` is 2'b10 (exclusive) or 2'b11 (modified) does not start.
- R4: The fence clears at the first clock edge where `wbe_n` is sampled 0. A write held by the fence starts in the clock that follows that edge, and not earlier.
- R5: Reads, and writes whose `req_state` is 2'b00 (invalid) or 2'b01 (shared), are not held by the fence.
- R6: When `hold` is 1 at an edge while the bus is idle, `hlda` is 1 after that edge. In the clock where hold is seen, no cycle starts.
- R7: While a cycle is in progress, `hlda` stays 0 until the cycle ends. It rises at the edge where `cyc_done` is 1 and `hold` is 1.
- R8: `bus_oe` is 0 in exactly the clocks where `hlda` is 1.
- R9: When `hold` is sampled 0 while acknowledged, `hlda` falls at that edge. No cycle starts in the following clock. A pending request starts in the clock after that.
- R10: No cycle starts while `hlda` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Queue head holds a request |
| req_write | input | 1 | Request is a write (1) or a read (0) |
| req_state | input | 2 | Cache state of the write target: 00 I, 01 S, 10 E, 11 M |
| wbe_n | input | 1 | External write buffer empty, active low |
| hold | input | 1 | Bus request from another master |
| cyc_done | input | 1 | Current bus cycle ends in this clock |
| cyc_start | output | 1 | Launch the head request in this clock (also pops it) |
| hlda | output | 1 | Hold acknowledge |
| bus_oe | output | 1 | Bus driver enable, low while floated |

## Verification
The assertions assume that `cyc_done` is raised only while a cycle is in progress. They also assume that a request stays at the queue head until it is launched. The stimulus keeps to both rules. It asserts `cyc_done` only when the bench's own model says the bus is busy, and it holds request fields steady in directed phases. The random phase keeps `hold` sticky and makes `wbe_n` mostly inactive, so that fence and hold windows last long enough to overlap real traffic.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    typedef enum logic [1:0] {
        LS_INVALID = 2'b00,
        LS_SHARED  = 2'b01,
        LS_EXCL    = 2'b10,
        LS_MOD     = 2'b11
    } line_state_e;

    typedef enum logic [1:0] {
        HS_RUN    = 2'b00,
        HS_HELD   = 2'b01,
        HS_RESUME = 2'b10
    } hold_state_e;

    typedef struct packed {
        logic        valid;
        logic        write;
        line_state_e state;
    } bus_req_t;

    // A write to an owned line must wait behind external buffered writes.
    function automatic logic fence_applies(bus_req_t r);
        return r.write && ((r.state == LS_EXCL) || (r.state == LS_MOD));
    endfunction

endpackage

// File: rtl/bcg_cycle_track.sv
module bcg_cycle_track (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic done,
    output logic busy,
    output logic boundary
);
    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst)        busy_q <= 1'b0;
        else if (start) busy_q <= 1'b1;
        else if (done)  busy_q <= 1'b0;
    end

    assign busy     = busy_q;
    assign boundary = !busy_q || done;
endmodule

// File: rtl/bcg_wr_fence.sv
module bcg_wr_fence (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic start_is_write,
    input  logic wbe_n,
    output logic fence
);
    logic fence_q;

    always_ff @(posedge clk) begin
        if (rst)                          fence_q <= 1'b0;
        else if (!wbe_n)                  fence_q <= 1'b0;
        else if (start && start_is_write) fence_q <= 1'b1;
    end

    assign fence = fence_q;
endmodule

// File: rtl/bcg_hold_ctl.sv
module bcg_hold_ctl
    import bcg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic boundary,
    output logic hlda,
    output logic bus_oe,
    output logic run_ok
);
    hold_state_e st_q, st_d;
    logic        hlda_q, oe_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HS_RUN:    if (hold && boundary) st_d = HS_HELD;
            HS_HELD:   if (!hold)            st_d = HS_RESUME;
            HS_RESUME:                       st_d = HS_RUN;
            default:                         st_d = HS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= HS_RUN;
            hlda_q <= 1'b0;
            oe_q   <= 1'b1;
        end else begin
            st_q   <= st_d;
            hlda_q <= (st_d == HS_HELD);
            oe_q   <= (st_d != HS_HELD);
        end
    end

    assign hlda   = hlda_q;
    assign bus_oe = oe_q;
    assign run_ok = (st_q == HS_RUN);
endmodule

// File: rtl/bcg_issue_gate.sv
module bcg_issue_gate
    import bcg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [1:0] req_state,
    input  logic       wbe_n,
    input  logic       hold,
    input  logic       cyc_done,
    output logic       cyc_start,
    output logic       hlda,
    output logic       bus_oe
);
    bus_req_t req;
    logic     busy, boundary, fence, run_ok, blocked;

    assign req.valid = req_valid;
    assign req.write = req_write;
    assign req.state = line_state_e'(req_state);

    bcg_cycle_track u_track (
        .clk(clk), .rst(rst), .start(cyc_start), .done(cyc_done),
        .busy(busy), .boundary(boundary)
    );

    bcg_wr_fence u_fence (
        .clk(clk), .rst(rst), .start(cyc_start), .start_is_write(req.write),
        .wbe_n(wbe_n), .fence(fence)
    );

    bcg_hold_ctl u_hold (
        .clk(clk), .rst(rst), .hold(hold), .boundary(boundary),
        .hlda(hlda), .bus_oe(bus_oe), .run_ok(run_ok)
    );

    assign blocked   = fence && fence_applies(req);
    assign cyc_start = !rst && run_ok && !busy && req.valid && !hold && !blocked;
endmodule

// File: rtl/bcg_issue_gate_chk.sv
module bcg_issue_gate_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_write,
    input logic [1:0] req_state,
    input logic       wbe_n,
    input logic       hold,
    input logic       cyc_done,
    input logic       cyc_start,
    input logic       hlda,
    input logic       bus_oe
);
    logic busy_m, fence_m;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_m  <= 1'b0;
            fence_m <= 1'b0;
        end else begin
            if (cyc_start)     busy_m <= 1'b1;
            else if (cyc_done) busy_m <= 1'b0;
            if (!wbe_n)                      fence_m <= 1'b0;
            else if (cyc_start && req_write) fence_m <= 1'b1;
        end
    end

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) busy_m |-> !cyc_start); // R2
    AST_FENCE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (fence_m && req_valid && req_write && req_state[1]) |-> !cyc_start); // R3
    AST_HOLD_ACK: assert property (@(posedge clk) disable iff (rst) $rose(hlda) |-> $past(hold)); // R6
    AST_NO_EARLY_ACK: assert property (@(posedge clk) disable iff (rst)
        (busy_m && !cyc_done && !hlda) |=> !hlda); // R7
    AST_OE_FLOAT: assert property (@(posedge clk) disable iff (rst) bus_oe == !hlda); // R8
    AST_RESUME_GAP: assert property (@(posedge clk) disable iff (rst) $fell(hlda) |-> !cyc_start); // R9
    AST_NO_START_HELD: assert property (@(posedge clk) disable iff (rst) hlda |-> !cyc_start); // R10
endmodule

bind bcg_issue_gate bcg_issue_gate_chk u_chk (.*);

// File: tb/sim_bcg_issue_gate.sv
module sim_bcg_issue_gate;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0, req_write = 1'b0, wbe_n = 1'b1, hold = 1'b0, cyc_done = 1'b0;
    logic [1:0] req_state = 2'b00;
    logic       cyc_start, hlda, bus_oe;

    int checks = 0, errors = 0;
    bit done_flag = 0;

    // bench model: 0 run, 1 held, 2 resume
    int   m_hs = 0;
    logic m_busy = 0, m_fence = 0;

    always #2 clk = ~clk;

    bcg_issue_gate u0 (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic exp_start(logic r, logic v, logic w, logic [1:0] s, logic h);
        return !r && (m_hs == 0) && !m_busy && v && !h && !(m_fence && w && s[1]);
    endfunction

    task automatic step(input logic r, v, w, input logic [1:0] s, input logic wbe, h, d,
                        input string tag);
        logic es;
        @(negedge clk);
        rst = r; req_valid = v; req_write = w; req_state = s; wbe_n = wbe; hold = h; cyc_done = d;
        #1;
        es = exp_start(r, v, w, s, h);
        chk(cyc_start === es, tag, cyc_start, es, "cyc_start");
        chk(hlda === (m_hs == 1), tag, hlda, (m_hs == 1), "hlda");
        chk(bus_oe === (m_hs != 1), tag, bus_oe, (m_hs != 1), "bus_oe");
        @(posedge clk);
        if (r) begin
            m_hs = 0; m_busy = 0; m_fence = 0;
        end else begin
            logic bnd;
            bnd = !m_busy || d;
            if (!wbe) m_fence = 0; else if (es && w) m_fence = 1;
            if (es) m_busy = 1; else if (d) m_busy = 0;
            case (m_hs)
                0: if (h && bnd) m_hs = 1;
                1: if (!h) m_hs = 2;
                default: m_hs = 0;
            endcase
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        @(posedge clk);
        step(1, 1, 0, 2'b00, 1, 0, 0, "R1");
        step(1, 0, 0, 2'b00, 1, 0, 0, "R1");
        // R1: state right after reset release
        step(0, 0, 0, 2'b00, 1, 0, 0, "R1");
        chk(m_fence == 0 && hlda === 1'b0 && bus_oe === 1'b1, "R1", hlda, 0, "reset state");

        // R2: read launches when idle, then one cycle at a time
        step(0, 1, 0, 2'b00, 1, 0, 0, "R2");
        for (int i = 0; i < 3; i++) step(0, 1, 0, 2'b00, 1, 0, 0, "R2");
        step(0, 1, 0, 2'b00, 1, 0, 1, "R2");
        step(0, 1, 0, 2'b00, 1, 0, 0, "R2");
        step(0, 0, 0, 2'b00, 1, 0, 1, "R2");

        // R3: exclusive write with buffer busy arms fence; modified write waits
        step(0, 1, 1, 2'b10, 1, 0, 0, "R3");
        step(0, 0, 0, 2'b00, 1, 0, 1, "R3");
        for (int i = 0; i < 4; i++) step(0, 1, 1, 2'b11, 1, 0, 0, "R3");
        // R5: shared write and read pass the fence
        step(0, 1, 1, 2'b01, 1, 0, 0, "R5");
        step(0, 0, 0, 2'b00, 1, 0, 1, "R5");
        step(0, 1, 0, 2'b10, 1, 0, 0, "R5");
        step(0, 0, 0, 2'b00, 1, 0, 1, "R5");
        // R4: held write leaves one clock after buffer empties
        step(0, 1, 1, 2'b10, 0, 0, 0, "R4");
        step(0, 1, 1, 2'b10, 1, 0, 0, "R4");
        chk(m_busy == 1, "R4", m_busy, 1, "released write");
        step(0, 0, 0, 2'b00, 1, 0, 1, "R4");

        // R6/R8/R10: hold while idle
        step(0, 1, 0, 2'b00, 1, 1, 0, "R6");
        for (int i = 0; i < 3; i++) step(0, 1, 0, 2'b00, 1, 1, 0, "R10");
        // R9: release then resume gap
        step(0, 1, 0, 2'b00, 1, 0, 0, "R9");
        step(0, 1, 0, 2'b00, 1, 0, 0, "R9");
        step(0, 1, 0, 2'b00, 1, 0, 0, "R9");
        chk(m_busy == 1, "R9", m_busy, 1, "start after resume");

        // R7: hold during active cycle waits for its end
        for (int i = 0; i < 3; i++) step(0, 0, 0, 2'b00, 1, 1, 0, "R7");
        step(0, 0, 0, 2'b00, 1, 1, 1, "R7");
        step(0, 1, 0, 2'b00, 1, 1, 0, "R8");
        step(0, 1, 0, 2'b00, 1, 0, 0, "R9");

        // random traffic
        begin
            logic h;
            h = 0;
            for (int i = 0; i < 4000; i++) begin
                if ($urandom % 16 == 0) h = ~h;
                step(0, ($urandom % 4) != 0, $urandom % 2, 2'($urandom % 4),
                     ($urandom % 4) != 0, h, m_busy && ($urandom % 3 == 0), "R2");
            end
        end

        done_flag = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule